// File: doc/BRIEF.md
# Rectangle-Fit Placement Search Engine

This block chooses where a new task may be placed on a two-dimensional grid of processing cells. A host loads a small table of free rectangular regions. Each slot holds the cell address of the region's bottom-left corner, its height in rows and its width in columns. The host keeps the slots ordered so that larger areas come first. The block does not sort the table. It trusts the order it is given.

A requester asks for a footprint of some rows by some columns. The engine then scans the valid slots one per clock cycle.

- **First pass:** it takes the first region that holds the footprint as given.
- **Second pass:** it runs only if the first pass finds nothing. It scans the table again with the footprint turned by a quarter turn.
- **Completion:** a one-cycle completion pulse reports the chosen base address and a flag saying whether the turned fit was used. If neither pass finds a region, an unmappable pulse is raised alongside the completion pulse.

Both the table write port and the request port are valid/ready channels. A transfer happens on a rising edge where valid and ready are both high. Both ready signals are high exactly when no scan is running. A request or write offered during a scan is held off: it is neither lost nor acted upon. Its source must keep valid asserted until the engine is idle again. The result outputs are plain signals.

Top module: `rect_fit_engine`

## Requirements
- R1: After reset, `req_ready` and `wr_ready` are high, `done` and `unmappable` are low, `res_base` and `res_rot` are 0, and the table holds zero valid slots.
- R2: An accepted table write stores the base, rows and columns into slot `wr_slot`. It also sets the valid-slot count to `wr_count`, clamped to the table size. A slot number at or above the table size stores nothing.
- R3: The straight pass examines slots 0, 1, 2, … in that order. It picks the lowest-numbered valid slot whose rows are at least the requested rows and whose columns are at least the requested columns. It reports that slot's base with `res_rot` = 0.
- R4: The turned pass runs only if the straight pass finds no slot. It again picks the lowest-numbered valid slot, this time one whose rows are at least the requested columns and whose columns are at least the requested rows. It reports that slot's base with `res_rot` = 1.
- R5: If neither pass finds a slot, `done` and `unmappable` pulse together, and `res_base` and `res_rot` keep their previous values.
- R6: One slot is examined per cycle. Count the rising edges from the edge that accepts the request up to the edge that raises `done`, with N valid slots:
  - a straight hit at slot k takes k+1 edges;
  - a turned hit at slot k takes N+k+1 edges;
  - an unmappable result with N>0 takes 2N edges.
- R7: With zero valid slots, a request ends after 1 edge with `done` and `unmappable` high.
- R8: While a scan runs, `req_ready` is low. A request offered during the scan does not start a search and does not change the result. When the scan ends with that request withdrawn, no new scan begins.
- R9: While a scan runs, `wr_ready` is low and the table and count stay unchanged. A write held off in this way is accepted once the engine is idle, and later searches use the new table.
- R10: If a write and a request are accepted on the same edge, the scan that request starts already uses the written slot and count.
- R11: `done` lasts one cycle. `res_base` and `res_rot` change only on the edge that raises `done`.
- R12: Slots at or above the valid count are never chosen, even if they would fit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Table write offered |
| wr_ready | output | 1 | Table write can be taken (engine idle) |
| wr_slot | input | SLOT_W (4) | Slot number written |
| wr_base | input | ADDR_W (6) | Bottom-left cell address of the region |
| wr_rows | input | DIM_W (4) | Region height in rows |
| wr_cols | input | DIM_W (4) | Region width in columns |
| wr_count | input | CNT_W (4) | New number of valid slots |
| req_valid | input | 1 | Placement request offered |
| req_ready | output | 1 | Request can be taken (engine idle) |
| req_rows | input | DIM_W (4) | Requested rows |
| req_cols | input | DIM_W (4) | Requested columns |
| done | output | 1 | One-cycle completion pulse |
| unmappable | output | 1 | Pulses with `done` when no region fits |
| res_base | output | ADDR_W (6) | Base address of the chosen region |
| res_rot | output | 1 | 1 if the turned fit was chosen |

## Verification
A table write and a placement request can be accepted on the same clock edge. The bench provokes this by raising both valid signals together while the engine is idle. The written slot is the only one that fits, and it fits only when turned. The scan must therefore report that slot's base with the turn flag set, after exactly the latency the new count implies.

A second collision is also provoked: both a write and a fitting request are offered during a long failing scan. The bench judges two things here. The scan must end unmappable with its full latency. The held-off write must be taken on the first idle edge, while no second scan starts.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int unsigned DEF_SLOTS = 10;
  localparam int unsigned DEF_CELLS = 60;
  localparam int unsigned DEF_DIM_W = 4;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_state_e;

  typedef enum logic [0:0] {
    PASS_STRAIGHT = 1'b0,
    PASS_TURNED   = 1'b1
  } pass_e;
endpackage

// File: rtl/rfe_region_table.sv
module rfe_region_table #(
  parameter int unsigned SLOTS  = 10,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DIM_W  = 4,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [DIM_W-1:0]  wr_rows,
  input  logic [DIM_W-1:0]  wr_cols,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ADDR_W-1:0] rd_base,
  output logic [DIM_W-1:0]  rd_rows,
  output logic [DIM_W-1:0]  rd_cols,
  output logic [CNT_W-1:0]  count
);
  logic [ADDR_W-1:0] base_q [SLOTS];
  logic [DIM_W-1:0]  rows_q [SLOTS];
  logic [DIM_W-1:0]  cols_q [SLOTS];
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  count_clamped;
  logic              slot_legal;

  // Writes to slots past the end of the table store nothing; count is clamped.
  assign slot_legal    = (int'(wr_slot) < SLOTS);
  assign count_clamped = (int'(wr_count) > SLOTS) ? CNT_W'(SLOTS) : wr_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        base_q[s] <= '0;
        rows_q[s] <= '0;
        cols_q[s] <= '0;
      end
      count_q <= '0;
    end else if (we) begin
      count_q <= count_clamped;
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_legal && (wr_slot == SLOT_W'(s))) begin
          base_q[s] <= wr_base;
          rows_q[s] <= wr_rows;
          cols_q[s] <= wr_cols;
        end
      end
    end
  end

  always_comb begin
    rd_base = '0;
    rd_rows = '0;
    rd_cols = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_slot == SLOT_W'(s)) begin
        rd_base = base_q[s];
        rd_rows = rows_q[s];
        rd_cols = cols_q[s];
      end
    end
  end

  assign count = count_q;
endmodule

// File: rtl/rfe_fit_check.sv
module rfe_fit_check #(
  parameter int unsigned DIM_W  = 4,
  parameter bit          TURNED = 1'b0
) (
  input  logic [DIM_W-1:0] have_rows,
  input  logic [DIM_W-1:0] have_cols,
  input  logic [DIM_W-1:0] need_rows,
  input  logic [DIM_W-1:0] need_cols,
  output logic             fits
);
  generate
    if (TURNED) begin : g_turned
      // Footprint turned a quarter: its columns stand along the region's rows.
      assign fits = (have_rows >= need_cols) && (have_cols >= need_rows);
    end else begin : g_straight
      assign fits = (have_rows >= need_rows) && (have_cols >= need_cols);
    end
  endgenerate
endmodule

// File: rtl/rfe_scan_ctrl.sv
module rfe_scan_ctrl
  import rfe_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        fit_vec,
  input  logic [ADDR_W-1:0] slot_base,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              busy,
  output logic              done,
  output logic              unmappable,
  output logic [ADDR_W-1:0] res_base,
  output logic              res_rot
);
  scan_state_e       state_q;
  pass_e             pass_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W:0]    idx_next_wide;
  logic              in_range;
  logic              fit_now;
  logic              hit;
  logic              last_slot;

  assign idx_next_wide = {1'b0, idx_q} + (CNT_W+1)'(1);
  assign in_range      = (idx_q < count);
  assign fit_now       = (pass_q == PASS_TURNED) ? fit_vec[1] : fit_vec[0];
  assign hit           = in_range && fit_now;
  assign last_slot     = (idx_next_wide >= {1'b0, count});
  assign rd_slot       = idx_q[SLOT_W-1:0];
  assign busy          = (state_q == SCAN_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SCAN_IDLE;
      pass_q     <= PASS_STRAIGHT;
      idx_q      <= '0;
      done       <= 1'b0;
      unmappable <= 1'b0;
      res_base   <= '0;
      res_rot    <= 1'b0;
    end else begin
      done       <= 1'b0;
      unmappable <= 1'b0;
      case (state_q)
        SCAN_IDLE: begin
          if (start) begin
            state_q <= SCAN_RUN;
            pass_q  <= PASS_STRAIGHT;
            idx_q   <= '0;
          end
        end
        SCAN_RUN: begin
          if (hit) begin
            done     <= 1'b1;
            res_base <= slot_base;
            res_rot  <= (pass_q == PASS_TURNED);
            state_q  <= SCAN_IDLE;
          end else if (last_slot) begin
            if ((pass_q == PASS_STRAIGHT) && (count != '0)) begin
              pass_q <= PASS_TURNED;
              idx_q  <= '0;
            end else begin
              done       <= 1'b1;
              unmappable <= 1'b1;
              state_q    <= SCAN_IDLE;
            end
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        default: state_q <= SCAN_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rect_fit_engine.sv
module rect_fit_engine #(
  parameter int unsigned SLOTS  = rfe_pkg::DEF_SLOTS,
  parameter int unsigned CELLS  = rfe_pkg::DEF_CELLS,
  parameter int unsigned DIM_W  = rfe_pkg::DEF_DIM_W,
  localparam int unsigned ADDR_W = $clog2(CELLS),
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [DIM_W-1:0]  wr_rows,
  input  logic [DIM_W-1:0]  wr_cols,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DIM_W-1:0]  req_rows,
  input  logic [DIM_W-1:0]  req_cols,
  output logic              done,
  output logic              unmappable,
  output logic [ADDR_W-1:0] res_base,
  output logic              res_rot
);
  logic              busy;
  logic              start;
  logic              we;
  logic [SLOT_W-1:0] rd_slot;
  logic [ADDR_W-1:0] rd_base;
  logic [DIM_W-1:0]  rd_rows;
  logic [DIM_W-1:0]  rd_cols;
  logic [CNT_W-1:0]  tbl_count;
  logic [1:0]        fit_vec;
  logic [DIM_W-1:0]  need_rows_q;
  logic [DIM_W-1:0]  need_cols_q;

  assign req_ready = !busy;
  assign wr_ready  = !busy;
  assign start     = req_valid && req_ready;
  assign we        = wr_valid && wr_ready;

  // Requested footprint is captured on acceptance and held for the scan.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_rows_q <= '0;
      need_cols_q <= '0;
    end else if (start) begin
      need_rows_q <= req_rows;
      need_cols_q <= req_cols;
    end
  end

  rfe_region_table #(
    .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DIM_W(DIM_W),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .we(we),
    .wr_slot(wr_slot), .wr_base(wr_base), .wr_rows(wr_rows),
    .wr_cols(wr_cols), .wr_count(wr_count),
    .rd_slot(rd_slot), .rd_base(rd_base), .rd_rows(rd_rows),
    .rd_cols(rd_cols), .count(tbl_count)
  );

  generate
    for (genvar p = 0; p < 2; p++) begin : g_pass
      rfe_fit_check #(.DIM_W(DIM_W), .TURNED(p == 1)) u_fit (
        .have_rows(rd_rows), .have_cols(rd_cols),
        .need_rows(need_rows_q), .need_cols(need_cols_q),
        .fits(fit_vec[p])
      );
    end
  endgenerate

  rfe_scan_ctrl #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .count(tbl_count),
    .fit_vec(fit_vec), .slot_base(rd_base), .rd_slot(rd_slot),
    .busy(busy), .done(done), .unmappable(unmappable),
    .res_base(res_base), .res_rot(res_rot)
  );
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_ready,
  input logic              done,
  input logic              unmappable,
  input logic [ADDR_W-1:0] res_base,
  input logic              res_rot,
  input logic              busy,
  input logic [CNT_W-1:0]  tbl_count
);
  // R8
  accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |=> $stable(tbl_count));

  // R11
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  unmap_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmappable |-> done);

  // R11
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_base) && $stable(res_rot)));

  // R6
  done_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R7
  empty_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (tbl_count == '0)) |=> (done && unmappable));
endmodule

bind rect_fit_engine rfe_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .wr_ready(wr_ready), .done(done), .unmappable(unmappable),
  .res_base(res_base), .res_rot(res_rot), .busy(busy), .tbl_count(tbl_count)
);

// File: tb/tb_rect_fit_engine.sv
`timescale 1ns/1ps
module tb_rect_fit_engine;
  localparam int SLOTS = 10;
  localparam int AW = 6;
  localparam int DW = 4;
  localparam int SW = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [SW-1:0] wr_slot = '0;
  logic [AW-1:0] wr_base = '0;
  logic [DW-1:0] wr_rows = '0;
  logic [DW-1:0] wr_cols = '0;
  logic [CW-1:0] wr_count = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [DW-1:0] req_rows = '0;
  logic [DW-1:0] req_cols = '0;
  logic done, unmappable, res_rot;
  logic [AW-1:0] res_base;

  always #2 clk = ~clk;

  rect_fit_engine dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_slot(wr_slot), .wr_base(wr_base), .wr_rows(wr_rows), .wr_cols(wr_cols),
    .wr_count(wr_count), .req_valid(req_valid), .req_ready(req_ready),
    .req_rows(req_rows), .req_cols(req_cols), .done(done),
    .unmappable(unmappable), .res_base(res_base), .res_rot(res_rot)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int m_base [SLOTS];
  int m_rows [SLOTS];
  int m_cols [SLOTS];
  int m_cnt = 0;
  int last_base = 0;
  bit last_rot = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void predict(input int r, input int c, output int lat,
                                  output int base, output bit rot, output bit um);
    um = 1'b1; base = last_base; rot = last_rot;
    lat = (m_cnt == 0) ? 1 : 2 * m_cnt;
    for (int k = 0; k < m_cnt; k++)
      if (um && m_rows[k] >= r && m_cols[k] >= c) begin
        um = 1'b0; lat = k + 1; base = m_base[k]; rot = 1'b0;
      end
    for (int k = 0; k < m_cnt; k++)
      if (um && m_rows[k] >= c && m_cols[k] >= r) begin
        um = 1'b0; lat = m_cnt + k + 1; base = m_base[k]; rot = 1'b1;
      end
  endfunction

  task automatic write_slot(input int s, input int b, input int r, input int c, input int n);
    @(negedge clk);
    wr_valid = 1'b1; wr_slot = SW'(s); wr_base = AW'(b);
    wr_rows = DW'(r); wr_cols = DW'(c); wr_count = CW'(n);
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    if (s < SLOTS) begin m_base[s] = b; m_rows[s] = r; m_cols[s] = c; end
    m_cnt = (n > SLOTS) ? SLOTS : n;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    do begin
      @(posedge clk); lat++; @(negedge clk);
    end while (!done && lat < 100);
  endtask

  task automatic run_req(input int r, input int c, input string tag);
    int lat, e_lat, e_base;
    bit e_rot, e_um;
    predict(r, c, e_lat, e_base, e_rot, e_um);
    @(negedge clk);
    req_valid = 1'b1; req_rows = DW'(r); req_cols = DW'(c);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(lat);
    check(lat == e_lat, {tag, " R6 latency"}, lat, e_lat);
    check(unmappable == e_um, {tag, " unmappable R5"}, int'(unmappable), int'(e_um));
    check(int'(res_base) == e_base, {tag, " base R3/R4"}, int'(res_base), e_base);
    check(res_rot == e_rot, {tag, " rot R4"}, int'(res_rot), int'(e_rot));
    last_base = e_base; last_rot = e_rot;
    @(negedge clk);
    check(!done, {tag, " R11 pulse"}, int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int lat;
    bit busy_ok;
    void'($urandom(32'd20240611));
    for (int k = 0; k < SLOTS; k++) begin m_base[k] = 0; m_rows[k] = 0; m_cols[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    check(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
    check(done == 1'b0 && unmappable == 1'b0, "R1 pulses", int'(done), 0);
    check(res_base == '0 && res_rot == 1'b0, "R1 result", int'(res_base), 0);
    run_req(1, 1, "R1 empty after reset");

    // R2 directed table, slot 3 lies beyond the count
    write_slot(0, 10, 2, 8, 3);
    write_slot(1, 20, 4, 4, 3);
    write_slot(2, 30, 6, 2, 3);
    write_slot(3, 40, 9, 9, 3);
    write_slot(12, 50, 15, 15, 3);   // R2 illegal slot stores nothing
    run_req(3, 3, "R3 first fit slot1");
    check(res_base == 6'd20, "R3 literal base", int'(res_base), 20);
    run_req(2, 6, "R3 slot0");
    run_req(7, 2, "R4 turned slot0");
    check(res_rot == 1'b1 && res_base == 6'd10, "R4 literal", int'(res_base), 10);
    run_req(8, 8, "R12 slot3 excluded");
    check(res_base == 6'd10, "R5 base held", int'(res_base), 10);
    write_slot(9, 1, 1, 1, 0);
    run_req(1, 1, "R7 zero slots");

    // R8/R9 activity offered during a long failing scan
    for (int k = 0; k < SLOTS; k++) write_slot(k, k, 1, 1, SLOTS);
    @(negedge clk);
    req_valid = 1'b1; req_rows = 4'd5; req_cols = 4'd5;
    @(posedge clk);
    @(negedge clk);
    req_rows = 4'd1; req_cols = 4'd1;
    wr_valid = 1'b1; wr_slot = 4'd0; wr_base = 6'd33;
    wr_rows = 4'd6; wr_cols = 4'd6; wr_count = 4'd1;
    busy_ok = 1'b1; lat = 0;
    while (!done && lat < 100) begin
      if (req_ready || wr_ready) busy_ok = 1'b0;
      @(posedge clk); lat++; @(negedge clk);
    end
    check(busy_ok, "R8 ready low while busy", int'(busy_ok), 1);
    check(lat == 2 * SLOTS, "R6 full scan latency", lat, 2 * SLOTS);
    check(unmappable == 1'b1, "R8 late request ignored", int'(unmappable), 1);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    m_base[0] = 33; m_rows[0] = 6; m_cols[0] = 6; m_cnt = 1;
    check(req_ready == 1'b1 && done == 1'b0, "R8 no second scan", int'(req_ready), 1);
    run_req(5, 5, "R9 held write applied");

    // R10 write and request on the same edge
    @(negedge clk);
    wr_valid = 1'b1; wr_slot = 4'd0; wr_base = 6'd7;
    wr_rows = 4'd2; wr_cols = 4'd3; wr_count = 4'd1;
    req_valid = 1'b1; req_rows = 4'd3; req_cols = 4'd2;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; req_valid = 1'b0;
    m_base[0] = 7; m_rows[0] = 2; m_cols[0] = 3; m_cnt = 1;
    wait_done(lat);
    check(lat == 2, "R10 latency", lat, 2);
    check(res_base == 6'd7 && res_rot == 1'b1, "R10 new slot used", int'(res_base), 7);
    last_base = 7; last_rot = 1'b1;

    // Random tables and requests
    for (int t = 0; t < 40; t++) begin
      int n;
      n = int'($urandom_range(0, SLOTS));
      for (int k = 0; k < SLOTS; k++)
        write_slot(k, int'($urandom_range(0, 59)), int'($urandom_range(1, 10)),
                   int'($urandom_range(1, 10)), n);
      for (int q = 0; q < 5; q++)
        run_req(int'($urandom_range(1, 12)), int'($urandom_range(1, 12)), "R3/R4 random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule